// File: doc/BRIEF.md
# Triggered Six-Channel DMA Scheduler

This block is the channel scheduler and word sequencer of a six-channel DMA engine. Each channel has its own configuration: a trigger source, a burst length, the number of bursts that make up one transfer, source and destination base addresses, signed address steps, and an interrupt mode. A channel becomes pending only when its selected hardware trigger line pulses or its software trigger is raised. The block has no internal timebase, so nothing moves without a trigger.

At every burst boundary the scheduler picks one pending channel and moves that channel's burst one 16-bit word at a time. Each word is a read from the source address followed by a write to the destination address, both over a simple request/acknowledge memory port. After each word both addresses advance by their signed steps. The addresses carry over from one burst to the next until the transfer's bursts are used up. The next trigger then starts a fresh transfer from the base addresses.

Channels take turns round-robin. Channel 0 can optionally be made urgent, so that it wins every burst boundary at which it is pending. Each channel raises a one-cycle interrupt either when its transfer starts or when it completes. A sticky per-channel flag records a trigger that arrived while the channel was still waiting.

Top module: `dma_sched_top`

## Requirements
- R1: After reset `mem_req`, `irq` and `ovf` are all 0. An enabled channel that receives no trigger never causes a memory request.
- R2: Channel c is triggered by `sw_trig[c]` or by `trig_in[k]`, where k is the value of field c of `cfg_src` (bits c*3+2..c*3). Pulses on any other `trig_in` line have no effect on that channel.
- R3: While `cfg_en[c]` is 0, triggers for channel c are dropped. Enabling the channel later does not recall them.
- R4: Each serviced trigger moves one burst of (field c of `cfg_burst`, 4 bits) + 1 words. Each word is a read request (`mem_we`=0) at the source address, then a write request (`mem_we`=1) of the read data at the destination address. A request holds its address and data until `mem_ack`.
- R5: After every word, the source and destination addresses of the channel advance by the channel's 16-bit two's-complement steps. The advanced addresses carry into the next burst of the same transfer.
- R6: A transfer consists of (field c of `cfg_count`, 8 bits) + 1 bursts. After the last of them, the next trigger starts again from the base addresses.
- R7: With `cfg_irq_end[c]`=1, `irq[c]` pulses for one cycle, the cycle after the final write of the transfer is acknowledged. With `cfg_irq_end[c]`=0, it pulses in the cycle in which the transfer's first read request first appears. At most one `irq` bit is high in any cycle.
- R8: A trigger that arrives while channel c is still pending, and not being granted that cycle, sets `ovf[c]`. The flag stays set until reset. A single trigger never sets it.
- R9: With `cfg_ch0_hipri`=0, the next burst goes to the first pending channel after the one served last, wrapping from 5 to 0. After reset the search starts at channel 0.
- R10: With `cfg_ch0_hipri`=1, a pending channel 0 is granted at the next burst boundary ahead of all other pending channels. A burst already running is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 8 | Hardware trigger lines, one pulse per event |
| sw_trig | input | 6 | Software trigger, one bit per channel |
| cfg_en | input | 6 | Channel enable |
| cfg_src | input | 18 | Trigger line select, 3 bits per channel |
| cfg_burst | input | 24 | Words per burst minus one, 4 bits per channel |
| cfg_count | input | 48 | Bursts per transfer minus one, 8 bits per channel |
| cfg_src_addr | input | 96 | Source base address, 16 bits per channel |
| cfg_dst_addr | input | 96 | Destination base address, 16 bits per channel |
| cfg_src_step | input | 96 | Signed source step per word, 16 bits per channel |
| cfg_dst_step | input | 96 | Signed destination step per word, 16 bits per channel |
| cfg_irq_end | input | 6 | Interrupt mode: 1 on completion, 0 on start |
| cfg_ch0_hipri | input | 1 | Channel 0 wins every burst boundary when set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write when 1, a read when 0 |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request accepted (read data valid for reads) |
| mem_rdata | input | 16 | Read data |
| irq | output | 6 | Per-channel interrupt pulse |
| ovf | output | 6 | Sticky per-channel trigger overflow flag |

## Verification
The properties assume that the memory side raises `mem_ack` only while `mem_req` is high, for a single cycle per request. They also assume that a channel's configuration stays stable while that channel has a burst pending or running. The bench memory model acknowledges each request exactly one cycle after it sees it and then drops the acknowledge. The bench writes configuration only right after a reset, or while the channel it changes is idle and not pending. Trigger pulses are one cycle wide and are applied away from the clock edge, so each pulse counts as exactly one event.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    // Word mover phases: wait for a grant, read the source, write the destination.
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_state_e;

endpackage

// File: rtl/dma_trig_sel.sv
// Picks one hardware trigger line for a channel, merges the software trigger
// and gates the result with the channel enable.
module dma_trig_sel #(
    parameter int NSRC = 8,
    parameter int SW   = 3
) (
    input  logic [NSRC-1:0] hw_trig,
    input  logic            sw_trig,
    input  logic            chan_en,
    input  logic [SW-1:0]   src_sel,
    output logic            fire
);

    logic hit;

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (src_sel == SW'(k)) begin
                hit = hw_trig[k];
            end
        end
    end

    assign fire = chan_en & (sw_trig | hit);

endmodule

// File: rtl/dma_rr_arb.sv
// Round-robin choice among pending channels, with an optional override that
// lets channel 0 win whenever it is pending.
module dma_rr_arb #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic          prio0,
    input  logic [IW-1:0] last,
    output logic          valid,
    output logic [IW-1:0] idx
);

    int   cand;
    logic found;

    always_comb begin
        found = 1'b0;
        idx   = last;
        cand  = 0;
        if (prio0 && req[0]) begin
            found = 1'b1;
            idx   = '0;
        end
        for (int off = 1; off <= N; off++) begin
            cand = (int'(last) + off) % N;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
        valid = found;
    end

endmodule

// File: rtl/dma_chan_ctx.sv
// Per-channel context: pending flag, transfer-in-progress flag, remaining
// bursts, live source/destination addresses, interrupt pulse, overflow flag.
module dma_chan_ctx #(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          start,
    input  logic          word_done,
    input  logic          burst_end,
    input  logic [AW-1:0] base_src,
    input  logic [AW-1:0] base_dst,
    input  logic [AW-1:0] src_step,
    input  logic [AW-1:0] dst_step,
    input  logic [TW-1:0] count_cfg,
    input  logic          irq_at_end,
    output logic          pend,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic          irq,
    output logic          ovf
);

    typedef struct packed {
        logic          pend;
        logic          run;
        logic          ovf;
        logic          irq;
        logic [TW-1:0] left;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.irq = 1'b0;

        if (start) begin
            ctx_d.pend = 1'b0;
            if (!ctx_q.run) begin
                ctx_d.run  = 1'b1;
                ctx_d.left = count_cfg;
                ctx_d.src  = base_src;
                ctx_d.dst  = base_dst;
                ctx_d.irq  = !irq_at_end;
            end
        end

        if (word_done) begin
            ctx_d.src = ctx_q.src + src_step;
            ctx_d.dst = ctx_q.dst + dst_step;
        end

        if (burst_end) begin
            if (ctx_q.left == '0) begin
                ctx_d.run = 1'b0;
                ctx_d.irq = irq_at_end;
            end else begin
                ctx_d.left = ctx_q.left - 1'b1;
            end
        end

        if (fire) begin
            if (ctx_q.pend && !start) begin
                ctx_d.ovf = 1'b1;
            end
            ctx_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pend    = ctx_q.pend;
    assign cur_src = ctx_q.src;
    assign cur_dst = ctx_q.dst;
    assign irq     = ctx_q.irq;
    assign ovf     = ctx_q.ovf;

endmodule

// File: rtl/dma_sched_top.sv
module dma_sched_top
    import dma_sched_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int NSRC = 8,
    parameter int AW   = 16,
    parameter int DW   = 16,
    parameter int BW   = 4,
    parameter int TW   = 8,
    parameter int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   trig_in,
    input  logic [NCH-1:0]    sw_trig,
    input  logic [NCH-1:0]    cfg_en,
    input  logic [NCH*SW-1:0] cfg_src,
    input  logic [NCH*BW-1:0] cfg_burst,
    input  logic [NCH*TW-1:0] cfg_count,
    input  logic [NCH*AW-1:0] cfg_src_addr,
    input  logic [NCH*AW-1:0] cfg_dst_addr,
    input  logic [NCH*AW-1:0] cfg_src_step,
    input  logic [NCH*AW-1:0] cfg_dst_step,
    input  logic [NCH-1:0]    cfg_irq_end,
    input  logic              cfg_ch0_hipri,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    ovf
);

    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] sel;
        logic [CW-1:0] last;
        logic [BW-1:0] words;
        logic [DW-1:0] data;
    } eng_t;

    eng_t eng_q, eng_d;

    logic [NCH-1:0] fire;
    logic [NCH-1:0] pend_vec;
    logic [NCH-1:0] start;
    logic [NCH-1:0] word_done;
    logic [NCH-1:0] burst_end;
    logic [AW-1:0]  cur_src   [NCH];
    logic [AW-1:0]  cur_dst   [NCH];
    logic [BW-1:0]  burst_len [NCH];

    logic           arb_valid;
    logic [CW-1:0]  arb_idx;
    logic           eng_grant;

    // Per-channel trigger selection and context.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign burst_len[c] = cfg_burst[c*BW +: BW];
        assign start[c]     = eng_grant && (arb_idx == CW'(c));
        assign word_done[c] = (eng_q.st == ENG_WRITE) && mem_ack && (eng_q.sel == CW'(c));
        assign burst_end[c] = word_done[c] && (eng_q.words == '0);

        dma_trig_sel #(
            .NSRC (NSRC),
            .SW   (SW)
        ) u_trig (
            .hw_trig (trig_in),
            .sw_trig (sw_trig[c]),
            .chan_en (cfg_en[c]),
            .src_sel (cfg_src[c*SW +: SW]),
            .fire    (fire[c])
        );

        dma_chan_ctx #(
            .AW (AW),
            .TW (TW)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (fire[c]),
            .start      (start[c]),
            .word_done  (word_done[c]),
            .burst_end  (burst_end[c]),
            .base_src   (cfg_src_addr[c*AW +: AW]),
            .base_dst   (cfg_dst_addr[c*AW +: AW]),
            .src_step   (cfg_src_step[c*AW +: AW]),
            .dst_step   (cfg_dst_step[c*AW +: AW]),
            .count_cfg  (cfg_count[c*TW +: TW]),
            .irq_at_end (cfg_irq_end[c]),
            .pend       (pend_vec[c]),
            .cur_src    (cur_src[c]),
            .cur_dst    (cur_dst[c]),
            .irq        (irq[c]),
            .ovf        (ovf[c])
        );
    end

    dma_rr_arb #(
        .N  (NCH),
        .IW (CW)
    ) u_arb (
        .req   (pend_vec),
        .prio0 (cfg_ch0_hipri),
        .last  (eng_q.last),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    // Word mover: one grant per burst, then read/write pairs until the burst ends.
    always_comb begin
        eng_d     = eng_q;
        eng_grant = 1'b0;
        case (eng_q.st)
            ENG_IDLE: begin
                if (arb_valid) begin
                    eng_grant   = 1'b1;
                    eng_d.st    = ENG_READ;
                    eng_d.sel   = arb_idx;
                    eng_d.last  = arb_idx;
                    eng_d.words = burst_len[arb_idx];
                end
            end
            ENG_READ: begin
                if (mem_ack) begin
                    eng_d.data = mem_rdata;
                    eng_d.st   = ENG_WRITE;
                end
            end
            ENG_WRITE: begin
                if (mem_ack) begin
                    if (eng_q.words == '0) begin
                        eng_d.st = ENG_IDLE;
                    end else begin
                        eng_d.words = eng_q.words - 1'b1;
                        eng_d.st    = ENG_READ;
                    end
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.st   <= ENG_IDLE;
            eng_q.last <= CW'(NCH - 1);
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mem_req   = (eng_q.st != ENG_IDLE);
    assign mem_we    = (eng_q.st == ENG_WRITE);
    assign mem_addr  = (eng_q.st == ENG_WRITE) ? cur_dst[eng_q.sel] : cur_src[eng_q.sel];
    assign mem_wdata = eng_q.data;

endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
    parameter int NCH = 6,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mem_req,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic [DW-1:0]  mem_wdata,
    input logic           mem_ack,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] ovf,
    input logic           cfg_ch0_hipri,
    input logic [NCH-1:0] pend_vec,
    input logic           grant,
    input logic [CW-1:0]  grant_idx
);

    // R4: an unanswered request keeps its kind, address and data
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R4: an accepted read is followed by the write of that word
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R7: never more than one interrupt at once
    a_r7_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    // R7: each interrupt is a single-cycle pulse
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |=> ((irq & $past(irq)) == '0));

    // R8: overflow flags never clear outside reset
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> (($past(ovf) & ~ovf) == '0));

    // R9: a burst is only granted to a channel with a pending trigger
    a_r9_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> pend_vec[grant_idx]);

    // R10: urgent channel 0 wins a boundary whenever it is pending
    a_r10_hipri_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cfg_ch0_hipri && pend_vec[0]) |-> (grant_idx == '0));

endmodule

bind dma_sched_top dma_sched_chk #(
    .NCH (NCH),
    .AW  (AW),
    .DW  (DW),
    .CW  (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .irq           (irq),
    .ovf           (ovf),
    .cfg_ch0_hipri (cfg_ch0_hipri),
    .pend_vec      (pend_vec),
    .grant         (eng_grant),
    .grant_idx     (arb_idx)
);

// File: tb/tb_dma_sched_top.sv
`timescale 1ns/1ps
module tb_dma_sched_top;

    localparam int NCH  = 6;
    localparam int NSRC = 8;
    localparam int AW   = 16;
    localparam int DW   = 16;
    localparam int BW   = 4;
    localparam int TW   = 8;
    localparam int SW   = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   trig_in = '0;
    logic [NCH-1:0]    sw_trig = '0;
    logic [NCH-1:0]    cfg_en = '0;
    logic [NCH*SW-1:0] cfg_src = '0;
    logic [NCH*BW-1:0] cfg_burst = '0;
    logic [NCH*TW-1:0] cfg_count = '0;
    logic [NCH*AW-1:0] cfg_src_addr = '0;
    logic [NCH*AW-1:0] cfg_dst_addr = '0;
    logic [NCH*AW-1:0] cfg_src_step = '0;
    logic [NCH*AW-1:0] cfg_dst_step = '0;
    logic [NCH-1:0]    cfg_irq_end = '0;
    logic              cfg_ch0_hipri = 1'b0;
    logic              mem_req, mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic              mem_ack;
    logic [DW-1:0]     mem_rdata;
    logic [NCH-1:0]    irq, ovf;

    dma_sched_top #(
        .NCH(NCH), .NSRC(NSRC), .AW(AW), .DW(DW), .BW(BW), .TW(TW), .SW(SW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sw_trig(sw_trig),
        .cfg_en(cfg_en), .cfg_src(cfg_src), .cfg_burst(cfg_burst), .cfg_count(cfg_count),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .cfg_irq_end(cfg_irq_end), .cfg_ch0_hipri(cfg_ch0_hipri),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq), .ovf(ovf)
    );

    // Memory model, read log and interrupt counters.
    logic [DW-1:0] mem    [0:255];
    logic [AW-1:0] rd_log [0:63];
    int            rd_n;
    int            irq_cnt [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= DW'(32'hC000 + i);
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_n      <= 0;
            for (int i = 0; i < NCH; i++) irq_cnt[i] <= 0;
        end else begin
            for (int i = 0; i < NCH; i++) if (irq[i]) irq_cnt[i] <= irq_cnt[i] + 1;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:0]];
            end else begin
                mem_ack <= 1'b0;
            end
            if (mem_req && mem_ack && !mem_we && rd_n < 64) begin
                rd_log[rd_n[5:0]] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int init_val(input int a);
        return 32'hC000 + a;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trig_in = '0; sw_trig = '0; cfg_en = '0; cfg_src = '0; cfg_burst = '0;
        cfg_count = '0; cfg_src_addr = '0; cfg_dst_addr = '0; cfg_src_step = '0;
        cfg_dst_step = '0; cfg_irq_end = '0; cfg_ch0_hipri = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_chan(input int c, input int en, input int src, input int burst,
                            input int count, input int sa, input int da,
                            input int ss, input int ds, input int irq_end);
        cfg_en[c]                 = en[0];
        cfg_src[c*SW +: SW]       = SW'(src);
        cfg_burst[c*BW +: BW]     = BW'(burst);
        cfg_count[c*TW +: TW]     = TW'(count);
        cfg_src_addr[c*AW +: AW]  = AW'(sa);
        cfg_dst_addr[c*AW +: AW]  = AW'(da);
        cfg_src_step[c*AW +: AW]  = AW'(ss);
        cfg_dst_step[c*AW +: AW]  = AW'(ds);
        cfg_irq_end[c]            = irq_end[0];
    endtask

    task automatic pulse_sw(input logic [NCH-1:0] mask);
        @(negedge clk);
        sw_trig = mask;
        @(negedge clk);
        sw_trig = '0;
    endtask

    task automatic pulse_hw(input int line);
        @(negedge clk);
        trig_in[line] = 1'b1;
        @(negedge clk);
        trig_in = '0;
    endtask

    task automatic wait_quiet(input string req);
        int quiet = 0;
        int n = 0;
        while (quiet < 3 && n < 3000) begin
            @(negedge clk);
            n++;
            if (mem_req) quiet = 0;
            else         quiet++;
        end
        if (quiet < 3) check_eq(req, "engine never went quiet", 0, 1);
    endtask

    // R1: reset state and no activity without a trigger
    task automatic t_reset_idle();
        do_reset();
        check_eq("R1", "mem_req after reset", int'(mem_req), 0);
        check_eq("R1", "irq after reset", int'(irq), 0);
        check_eq("R1", "ovf after reset", int'(ovf), 0);
        set_chan(0, 1, 0, 0, 0, 16'h10, 16'h80, 1, 1, 1);
        repeat (60) @(negedge clk);
        check_eq("R1", "reads with no trigger", rd_n, 0);
    endtask

    // R4 R5 R7: one 4-word burst, unit steps, interrupt on completion
    task automatic t_basic_burst();
        do_reset();
        set_chan(2, 1, 0, 3, 0, 16'h10, 16'h80, 1, 1, 1);
        pulse_sw(6'b000100);
        wait_quiet("R4");
        for (int i = 0; i < 4; i++)
            check_eq("R4", "copied word", int'(mem[8'h80 + i]), init_val(16'h10 + i));
        check_eq("R4", "word past burst untouched", int'(mem[8'h84]), init_val(16'h84));
        check_eq("R7", "end irq count ch2", irq_cnt[2], 1);
        check_eq("R7", "irq count ch0", irq_cnt[0], 0);
    endtask

    // R2 R5: trigger line select, step of +2 and -1
    task automatic t_steps_and_select();
        do_reset();
        set_chan(1, 1, 5, 3, 0, 16'h20, 16'h9F, 2, -1, 1);
        pulse_hw(4);
        repeat (20) @(negedge clk);
        check_eq("R2", "unselected line ignored", rd_n, 0);
        pulse_hw(5);
        wait_quiet("R2");
        check_eq("R2", "selected line starts burst", rd_n, 4);
        for (int i = 0; i < 4; i++)
            check_eq("R5", "stepped word", int'(mem[8'h9F - i]), init_val(16'h20 + 2 * i));
    endtask

    // R5 R6 R7: three bursts of two words per transfer, reload on the next transfer
    task automatic t_multi_burst();
        do_reset();
        set_chan(3, 1, 0, 1, 2, 16'h30, 16'hA0, 1, 1, 1);
        pulse_sw(6'b001000);
        wait_quiet("R6");
        check_eq("R6", "first burst word 1", int'(mem[8'hA1]), init_val(16'h31));
        check_eq("R6", "beyond first burst untouched", int'(mem[8'hA2]), init_val(16'hA2));
        check_eq("R7", "no irq mid transfer", irq_cnt[3], 0);
        pulse_sw(6'b001000);
        wait_quiet("R5");
        pulse_sw(6'b001000);
        wait_quiet("R6");
        check_eq("R5", "address carried to third burst", int'(mem[8'hA5]), init_val(16'h35));
        check_eq("R7", "irq after last burst", irq_cnt[3], 1);
        pulse_sw(6'b001000);
        wait_quiet("R6");
        check_eq("R6", "new transfer restarts at base", int'(rd_log[6]), 16'h30);
        check_eq("R7", "no irq at start in end mode", irq_cnt[3], 1);
    endtask

    // R7: interrupt at transfer start
    task automatic t_irq_start();
        int n = 0;
        do_reset();
        set_chan(4, 1, 0, 0, 1, 16'h08, 16'hB0, 1, 1, 0);
        pulse_sw(6'b010000);
        while (!mem_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        check_eq("R7", "irq with first read request", int'(irq[4]), 1);
        wait_quiet("R7");
        check_eq("R7", "start irq count", irq_cnt[4], 1);
        pulse_sw(6'b010000);
        wait_quiet("R7");
        check_eq("R7", "no irq on completion in start mode", irq_cnt[4], 1);
    endtask

    // R9: round-robin order
    task automatic t_round_robin();
        do_reset();
        for (int c = 0; c < NCH; c++) set_chan(c, 1, 2, 0, 0, 16'h40 + c, 16'hC0 + c, 1, 1, 1);
        pulse_hw(2);
        wait_quiet("R9");
        for (int i = 0; i < NCH; i++)
            check_eq("R9", "service order all pending", int'(rd_log[i]), 16'h40 + i);

        do_reset();
        set_chan(0, 1, 0, 3, 0, 16'h40, 16'hC0, 1, 1, 1);
        set_chan(2, 1, 0, 0, 0, 16'h42, 16'hD0, 1, 1, 1);
        pulse_sw(6'b000101);
        repeat (3) @(negedge clk);
        pulse_sw(6'b000001);
        wait_quiet("R9");
        check_eq("R9", "ch0 first burst", int'(rd_log[3]), 16'h43);
        check_eq("R9", "ch2 before repeat of ch0", int'(rd_log[4]), 16'h42);
        check_eq("R9", "ch0 served again", int'(rd_log[5]), 16'h40);
        check_eq("R9", "total reads", rd_n, 9);
    endtask

    // R10: urgent channel 0 against round-robin
    task automatic hipri_run(input bit hp, input int exp4, input int exp5);
        do_reset();
        cfg_ch0_hipri = hp;
        set_chan(0, 1, 0, 0, 0, 16'h50, 16'hE0, 1, 1, 1);
        set_chan(3, 1, 0, 3, 0, 16'h60, 16'hE8, 1, 1, 1);
        set_chan(4, 1, 0, 0, 0, 16'h70, 16'hF0, 1, 1, 1);
        pulse_sw(6'b011000);
        repeat (4) @(negedge clk);
        pulse_sw(6'b000001);
        wait_quiet("R10");
        for (int i = 0; i < 4; i++)
            check_eq("R10", "running burst not cut", int'(rd_log[i]), 16'h60 + i);
        check_eq("R10", "fifth read", int'(rd_log[4]), exp4);
        check_eq("R10", "sixth read", int'(rd_log[5]), exp5);
    endtask

    task automatic t_hipri();
        hipri_run(1'b1, 16'h50, 16'h70);
        hipri_run(1'b0, 16'h70, 16'h50);
    endtask

    // R8: overflow when triggered while still pending
    task automatic t_overflow();
        do_reset();
        set_chan(0, 1, 0, 7, 0, 16'h00, 16'h80, 1, 1, 1);
        set_chan(1, 1, 0, 0, 0, 16'h20, 16'h90, 1, 1, 1);
        pulse_sw(6'b000001);
        repeat (2) @(negedge clk);
        pulse_sw(6'b000010);
        check_eq("R8", "single trigger no overflow", int'(ovf), 0);
        repeat (2) @(negedge clk);
        pulse_sw(6'b000010);
        wait_quiet("R8");
        check_eq("R8", "overflow flags", int'(ovf), 6'b000010);
        check_eq("R8", "ch1 burst ran once", irq_cnt[1], 1);
    endtask

    // R3: disabled channel drops triggers
    task automatic t_disabled();
        do_reset();
        set_chan(5, 0, 1, 0, 0, 16'h05, 16'hF8, 1, 1, 1);
        pulse_sw(6'b100000);
        pulse_hw(1);
        repeat (30) @(negedge clk);
        check_eq("R3", "disabled channel idle", rd_n, 0);
        cfg_en[5] = 1'b1;
        repeat (30) @(negedge clk);
        check_eq("R3", "enable does not recall trigger", rd_n, 0);
        pulse_sw(6'b100000);
        wait_quiet("R3");
        check_eq("R3", "enabled channel serves trigger", rd_n, 1);
    endtask

    initial begin
        t_reset_idle();
        t_basic_burst();
        t_steps_and_select();
        t_multi_burst();
        t_irq_start();
        t_round_robin();
        t_hipri();
        t_overflow();
        t_disabled();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule